// File: doc/BRIEF.md
# Dual-Mode Interrupt Down-Counter

This block is a programmable interrupt timer for a cartridge-side controller. Software sets a reload value and picks one of two count sources: completed visible scanlines while rendering is on, or CPU cycles divided by four. It then arms the interrupt. The counter counts down. When it steps from zero to its terminal value of minus one, it raises a level interrupt request, if the interrupt is enabled. The counter then stays at minus one until software loads it again.

Software drives the block through four write-only registers. The block decodes the address with a mask, so the aliases of each register also work. The arm register loads the counter and sets a sticky reload flag. While that flag is set, writes to the latch, acknowledge and enable registers also copy the latch into the counter. In scanline mode, each scanline-end event clears the flag, and an interrupt that fires in scanline mode sets it again. The request stays high until software writes the acknowledge register.

Top module: `dual_mode_irq_timer`

## Requirements
- R1: A write acts only when `wr_addr & 16'hF003` equals 16'hC000 (latch), 16'hC001 (arm), 16'hE000 (acknowledge) or 16'hE001 (enable). Writes to any other address leave the interrupt line and the count unchanged.
- R2: A latch write stores `wr_data` as the reload value. If the reload flag is set, the counter is also loaded with the new value in the same cycle. If the flag is clear, the counter is not changed.
- R3: An arm write sets the reload flag and copies the stored latch into the counter. It selects cycle mode when `wr_data[0]` is 1 and scanline mode when it is 0.
- R4: An acknowledge write disables the interrupt and drops `irq` after the edge that takes the write. If the reload flag is set, it also reloads the counter from the latch.
- R5: An enable write enables the interrupt. If the reload flag is set, it also reloads the counter from the latch.
- R6: In cycle mode, the counter steps down once every fourth `cpu_tick`, counted by a 2-bit prescaler. `line_end` has no effect on the count in this mode.
- R7: In scanline mode, a `line_end` pulse steps the counter down only when `line_num` is 239 or less and `render_on` is 1. Every `line_end` in this mode clears the reload flag. `cpu_tick` has no effect in this mode.
- R8: A step happens only while the counter is non-negative. The step from 0 to -1 raises `irq` after the same edge if the interrupt is enabled. The counter then holds at -1 and raises no further request.
- R9: An interrupt that fires in scanline mode sets the reload flag again.
- R10: Once raised, `irq` stays high until an acknowledge write.
- R11: After reset, `irq` is low. Latch, counter, prescaler and reload flag are zero, the interrupt is disabled, and scanline mode is selected.
- R12: When a counter load and a step fall in the same cycle, the load wins and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU register write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_tick | input | 1 | One pulse per CPU cycle |
| line_end | input | 1 | One pulse at the end of each scanline |
| line_num | input | 9 | Number of the scanline that just ended |
| render_on | input | 1 | Rendering enabled |
| irq | output | 1 | Level interrupt request, active high |

## Verification
Every write, tick and scanline pulse is applied for one cycle and acts on the rising edge that samples it. The counter and `irq` change at that same edge, with no further pipeline stage, so a request that fires or is acknowledged is visible directly after that edge. The bench drives each stimulus at a falling edge, holds it for one cycle, and reads `irq` at the next falling edge. That read point is exactly one edge after the stimulus. The count is not visible at the ports, so it is checked through timing: the bench reads `irq` one event before the expected underflow and again on the event itself.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 16'hF003;
  localparam logic [ADDR_W-1:0] REG_LATCH  = 16'hC000;
  localparam logic [ADDR_W-1:0] REG_ARM    = 16'hC001;
  localparam logic [ADDR_W-1:0] REG_ACK    = 16'hE000;
  localparam logic [ADDR_W-1:0] REG_ENABLE = 16'hE001;

  typedef enum logic {
    MODE_LINE  = 1'b0,
    MODE_CYCLE = 1'b1
  } count_mode_e;

  typedef struct packed {
    logic latch_wr;
    logic arm_wr;
    logic ack_wr;
    logic enable_wr;
  } wr_strobe_t;

  function automatic logic addr_hits(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    return (a & ADDR_MASK) == base;
  endfunction

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_timer_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_strobe_t        strobe
);

  always_comb begin
    strobe.latch_wr  = wr_en && addr_hits(wr_addr, REG_LATCH);
    strobe.arm_wr    = wr_en && addr_hits(wr_addr, REG_ARM);
    strobe.ack_wr    = wr_en && addr_hits(wr_addr, REG_ACK);
    strobe.enable_wr = wr_en && addr_hits(wr_addr, REG_ENABLE);
  end

endmodule

// File: rtl/irq_step_gen.sv
module irq_step_gen
  import irq_timer_pkg::*;
#(
  parameter int PRESC_W   = 2,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  count_mode_e       mode,
  input  logic              cpu_tick,
  input  logic              line_end,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              cyc_step,
  output logic              line_seen,
  output logic              line_step
);

  localparam logic [PRESC_W-1:0] PRESC_TOP  = '1;
  localparam logic [LINE_W-1:0]  LINE_LIMIT = LINE_W'(LAST_LINE);

  function automatic logic line_visible(input logic [LINE_W-1:0] n);
    return n <= LINE_LIMIT;
  endfunction

  logic [PRESC_W-1:0] presc_q;
  logic               presc_adv;

  assign presc_adv = (mode == MODE_CYCLE) && cpu_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)         presc_q <= '0;
    else if (presc_adv) presc_q <= presc_q + 1'b1;
  end

  assign cyc_step  = presc_adv && (presc_q == PRESC_TOP);
  assign line_seen = (mode == MODE_LINE) && line_end;
  assign line_step = line_seen && render_on && line_visible(line_num);

  AST_SOURCE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cyc_step, line_seen})); // R6
  AST_PRESC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_step |=> (presc_q == '0)); // R6
  AST_PRESC_IDLE_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LINE) |=> $stable(presc_q)); // R7

endmodule

// File: rtl/irq_count_core.sv
module irq_count_core
  import irq_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strobe_t        strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cyc_step,
  input  logic              line_seen,
  input  logic              line_step,
  output count_mode_e       mode,
  output logic              irq
);

  localparam int CNT_W = DATA_W + 1;
  localparam logic [CNT_W-1:0] CNT_TERMINAL = '1;

  function automatic logic still_counting(input logic [CNT_W-1:0] c);
    return !c[CNT_W-1];
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] widen(input logic [DATA_W-1:0] v);
    return {1'b0, v};
  endfunction

  logic [DATA_W-1:0] latch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              reload_q;
  logic              en_q;
  count_mode_e       mode_q;
  logic              irq_q;

  logic              load_now;
  logic [CNT_W-1:0]  load_val;
  logic              dec_ok;
  logic              underflow;
  logic              fire;

  assign load_now  = strobe.arm_wr ||
                     (reload_q && (strobe.latch_wr || strobe.ack_wr || strobe.enable_wr));
  assign load_val  = strobe.latch_wr ? widen(wr_data) : widen(latch_q);
  assign dec_ok    = (cyc_step || line_step) && !load_now && still_counting(cnt_q);
  assign underflow = dec_ok && (cnt_q == '0);
  assign fire      = underflow && en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= '0;
      cnt_q    <= '0;
      reload_q <= 1'b0;
      en_q     <= 1'b0;
      mode_q   <= MODE_LINE;
      irq_q    <= 1'b0;
    end else begin
      if (strobe.latch_wr) latch_q <= wr_data;

      if (load_now)    cnt_q <= load_val;
      else if (dec_ok) cnt_q <= step_down(cnt_q);

      if (strobe.arm_wr) reload_q <= 1'b1;
      else if (line_seen) reload_q <= fire;

      if (strobe.ack_wr)         en_q <= 1'b0;
      else if (strobe.enable_wr) en_q <= 1'b1;

      if (strobe.arm_wr) mode_q <= count_mode_e'(wr_data[0]);

      if (strobe.ack_wr) irq_q <= 1'b0;
      else if (fire)     irq_q <= 1'b1;
    end
  end

  assign mode = mode_q;
  assign irq  = irq_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe)); // R1
  AST_ARM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.arm_wr |=> (cnt_q == {1'b0, $past(latch_q)}) && reload_q); // R3
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ack_wr |=> !irq_q); // R4
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(en_q)); // R8
  AST_TERMINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TERMINAL) && !load_now |=> (cnt_q == CNT_TERMINAL)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !strobe.ack_wr |=> irq_q); // R10
  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> !cnt_q[CNT_W-1]); // R12

endmodule

// File: rtl/dual_mode_irq_timer.sv
module dual_mode_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int PRESC_W   = 2,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_tick,
  input  logic              line_end,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq
);

  wr_strobe_t  strobe;
  count_mode_e mode;
  logic        cyc_step;
  logic        line_seen;
  logic        line_step;

  irq_wr_decode u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strobe  (strobe)
  );

  irq_step_gen #(
    .PRESC_W   (PRESC_W),
    .LINE_W    (LINE_W),
    .LAST_LINE (LAST_LINE)
  ) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .cpu_tick  (cpu_tick),
    .line_end  (line_end),
    .line_num  (line_num),
    .render_on (render_on),
    .cyc_step  (cyc_step),
    .line_seen (line_seen),
    .line_step (line_step)
  );

  irq_count_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wr_data   (wr_data),
    .cyc_step  (cyc_step),
    .line_seen (line_seen),
    .line_step (line_step),
    .mode      (mode),
    .irq       (irq)
  );

endmodule

// File: tb/dual_mode_irq_timer_bench.sv
module dual_mode_irq_timer_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [15:0] A_LATCH  = 16'hC000;
  localparam logic [15:0] A_ARM    = 16'hC001;
  localparam logic [15:0] A_ACK    = 16'hE000;
  localparam logic [15:0] A_ENABLE = 16'hE001;

  typedef struct packed {
    logic        cyc_mode;
    logic [7:0]  reload;
    logic [15:0] events_to_fire;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd0, 16'd1},
    '{1'b0, 8'd3, 16'd4},
    '{1'b0, 8'd7, 16'd8},
    '{1'b1, 8'd0, 16'd1},
    '{1'b1, 8'd2, 16'd3},
    '{1'b1, 8'd5, 16'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cpu_tick = 1'b0;
  logic        line_end = 1'b0;
  logic [8:0]  line_num = '0;
  logic        render_on = 1'b1;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_irq_timer u_dual_mode_irq_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cpu_tick  (cpu_tick),
    .line_end  (line_end),
    .line_num  (line_num),
    .render_on (render_on),
    .irq       (irq)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq=%b expected %b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic line(input logic [8:0] n, input logic r);
    @(negedge clk);
    line_end = 1'b1; line_num = n; render_on = r;
    @(negedge clk);
    line_end = 1'b0;
  endtask

  task automatic wr_and_line(input logic [15:0] a, input logic [7:0] d, input logic [8:0] n);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    line_end = 1'b1; line_num = n; render_on = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; line_end = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_tick = 1'b1;
      @(negedge clk);
      cpu_tick = 1'b0;
    end
  endtask

  task automatic one_event(input logic cyc_mode);
    if (cyc_mode) ticks(4);
    else line(9'd10, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state, counter 0 in scanline mode
    check("R11 irq low after reset", 1'b0);
    wr(A_ENABLE, 8'h00);
    line(9'd0, 1'b1);
    check("R11 zero count fires on first line", 1'b1);
    // R10: request persists without acknowledge
    line(9'd5, 1'b1);
    ticks(4);
    check("R10 irq held until ack", 1'b1);
    // R1: non-matching addresses are ignored, aliases act
    wr(16'hE002, 8'h00);
    wr(16'hF001, 8'h00);
    wr(16'hD000, 8'h00);
    check("R1 unmatched writes ignored", 1'b1);
    wr(16'hE00C, 8'h00);
    check("R1 aliased ack acts", 1'b0);

    // vector table: R3 R6 R7 R8 R4
    for (int v = 0; v < NVEC; v++) begin
      wr(A_ACK, 8'h00);
      wr(A_LATCH, VECS[v].reload);
      wr(A_ARM, {7'd0, VECS[v].cyc_mode});
      wr(A_ENABLE, 8'h00);
      for (int e = 1; e < int'(VECS[v].events_to_fire); e++) one_event(VECS[v].cyc_mode);
      check(VECS[v].cyc_mode ? "R6 no irq before underflow" : "R7 no irq before underflow", 1'b0);
      one_event(VECS[v].cyc_mode);
      check("R8 irq on underflow (R3 load)", 1'b1);
      wr(A_ACK, 8'h00);
      check("R4 ack clears irq", 1'b0);
    end

    // R2: latch write loads counter at once while flag set (cycle mode)
    wr(A_LATCH, 8'd0);
    wr(A_ARM, 8'h01);
    wr(A_LATCH, 8'd5);
    wr(A_ENABLE, 8'h00);
    ticks(23);
    check("R2 immediate reload delays fire", 1'b0);
    ticks(1);
    check("R2 fire after 6 steps", 1'b1);
    wr(A_ACK, 8'h00);

    // R4 disabled underflow, R5 enable reloads
    wr(A_LATCH, 8'd1);
    wr(A_ARM, 8'h01);
    wr(A_ACK, 8'h00);
    ticks(8);
    check("R4 no irq while disabled", 1'b0);
    wr(A_ENABLE, 8'h00);
    ticks(7);
    check("R5 enable reloaded counter", 1'b0);
    ticks(1);
    check("R5 fire after reload", 1'b1);
    wr(A_ACK, 8'h00);

    // R7 qualifiers, R6 ticks ignored in line mode, R2 no load with flag clear
    wr(A_LATCH, 8'd3);
    wr(A_ARM, 8'h00);
    wr(A_ENABLE, 8'h00);
    line(9'd240, 1'b1);
    line(9'd5, 1'b0);
    ticks(8);
    wr(A_LATCH, 8'd0);
    line(9'd239, 1'b1);
    line(9'd0, 1'b1);
    line(9'd100, 1'b1);
    check("R7 line 240, render off and ticks skipped", 1'b0);
    line(9'd120, 1'b1);
    check("R2 latch write without flag kept count", 1'b1);

    // R9: fire in line mode re-arms reload flag
    wr(A_LATCH, 8'd1);
    wr(A_ACK, 8'h00);
    check("R9 ack after fire", 1'b0);
    wr(A_ENABLE, 8'h00);
    line(9'd1, 1'b1);
    check("R9 one step left", 1'b0);
    line(9'd2, 1'b1);
    check("R9 reload flag restored by fire", 1'b1);

    // R8: counter holds at -1
    line(9'd3, 1'b1);
    wr(A_ACK, 8'h00);
    wr(A_ENABLE, 8'h00);
    line(9'd4, 1'b1);
    line(9'd4, 1'b1);
    line(9'd4, 1'b1);
    check("R8 no second underflow at -1", 1'b0);

    // R12: load beats step in the same cycle
    wr(A_LATCH, 8'd0);
    wr(A_ARM, 8'h00);
    wr(A_ENABLE, 8'h00);
    wr_and_line(A_ENABLE, 8'h00, 9'd7);
    check("R12 load wins over step", 1'b0);
    line(9'd8, 1'b1);
    check("R12 next step fires", 1'b1);
    wr(A_ACK, 8'h00);
    check("R4 final ack", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule